// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge target. A configuration decoder upstream hands it one access per cycle: a starting byte offset, a length in bytes and, for writes, a 32-bit data word. Reads gather consecutive bytes into a little-endian word that comes back one cycle later. Writes scatter the data lanes byte by byte into storage.

A few bytes carry fixed identity values. Two offsets silently drop writes. A group of other bytes load defined values on reset. The seven bytes that a shadow memory attribute decoder consumes are presented on a dedicated output bus, so that decoder needs no access cycles of its own.

Top module: `hb_cfg_space`

## Requirements
- R1: Bytes 0x00, 0x01, 0x02 and 0x03 always read 0x86, 0x80, 0x37 and 0x12, and byte 0x0B always reads 0x06. Writes to these five bytes leave them unchanged.
- R2: After reset, byte 0x04 reads 0x06, byte 0x06 reads 0x80 and byte 0x07 reads 0x02. Bytes 0x05, 0x0D and 0x0F read 0x00.
- R3: After reset, byte 0x51 reads 0x01, byte 0x53 reads 0x80, byte 0x57 reads 0x01 and byte 0x58 reads 0x10. Bytes 0x50, 0x52, 0x54 to 0x56 and 0x59 to 0x5F read 0x00. Every byte not named in R1 to R3 reads 0x00.
- R4: A read with length L from 1 to 4 returns byte offset+i in bits [8i+7:8i] for each i below L. All higher bits are zero. The result appears on rsp_rdata with rsp_valid high in the cycle after the request.
- R5: A read with length 5, 6 or 7 returns 0xFFFFFFFF. A read of length 0 returns 0. A write with length 0 or above 4 changes no byte.
- R6: A write with length L from 1 to 4 stores bits [8i+7:8i] of req_wdata into byte offset+i for each i below L. The new value is visible to a read issued in the next cycle.
- R7: Write lanes that land on byte 0x06 or byte 0x0C are discarded. The other lanes of the same write are still stored.
- R8: Lanes whose byte index offset+i would exceed 0xFF are clipped: they are not written, and they read as zero.
- R9: shadow_attr carries bytes 0x59 to 0x5F, with byte 0x59+k in bits [8k+7:8k]. It shows the value held by storage, including a write's effect from the clock edge that stores it.
- R10: rsp_valid is high in exactly those cycles that follow a cycle with req_valid high and req_write low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Starting byte offset |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, little-endian |
| shadow_attr | output | 56 | Bytes 0x59..0x5F for the shadow attribute decoder |

## Verification
The hardest case to reach from the ports is a multi-byte access that straddles a masked or fixed byte, or that runs past offset 0xFF. There, some lanes must land and the lanes beside them must not. The bench writes at every offset with every length from 1 to 4, so every lane of every access crosses each masked byte, each identity byte and the top of the space. After each pass it reads back all 256 offsets as 4-byte words and compares them against a byte model that applies the masking and clipping rules.

// File: rtl/hbcfg_pkg.sv
// Package: shared constants and per-byte policy functions for the host
// bridge configuration space. Assumes a 256-byte, byte-addressed space.
package hbcfg_pkg;
    localparam int CFG_AW      = 8;
    localparam int CFG_BYTES   = 1 << CFG_AW;
    localparam int LANES       = 4;
    localparam int LEN_W       = 3;
    localparam int SHADOW_BASE = 'h59;
    localparam int SHADOW_N    = 7;

    // Value a byte holds after reset (identity bytes keep it forever).
    function automatic logic [7:0] reset_value(input logic [CFG_AW-1:0] idx);
        case (idx)
            8'h00: reset_value = 8'h86;
            8'h01: reset_value = 8'h80;
            8'h02: reset_value = 8'h37;
            8'h03: reset_value = 8'h12;
            8'h0B: reset_value = 8'h06;
            8'h04: reset_value = 8'h06;
            8'h06: reset_value = 8'h80;
            8'h07: reset_value = 8'h02;
            8'h51: reset_value = 8'h01;
            8'h53: reset_value = 8'h80;
            8'h57: reset_value = 8'h01;
            8'h58: reset_value = 8'h10;
            default: reset_value = 8'h00;
        endcase
    endfunction

    // Whether a write lane landing on this byte is kept.
    function automatic logic byte_writable(input logic [CFG_AW-1:0] idx);
        case (idx)
            8'h00, 8'h01, 8'h02, 8'h03, 8'h0B: byte_writable = 1'b0;
            8'h06, 8'h0C:                      byte_writable = 1'b0;
            default:                           byte_writable = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/hbcfg_lane_map.sv
// Lane mapper: turns an offset and length into one byte index and one
// enable per data lane. Assumes lengths above LANES are invalid accesses;
// lanes whose index passes the top of the space are disabled (clipped).
module hbcfg_lane_map
    import hbcfg_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int NL = LANES,
    parameter int LW = LEN_W
) (
    input  logic [AW-1:0]          offset,
    input  logic [LW-1:0]          len,
    output logic [NL-1:0][AW-1:0]  lane_idx,
    output logic [NL-1:0]          lane_on,
    output logic                   len_bad
);
    // Flag lengths wider than the data word.
    always_comb len_bad = (int'(len) > NL);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [AW:0] sum;
        // Per-lane byte index with carry for clip detection.
        always_comb begin
            sum         = {1'b0, offset} + (AW+1)'(i);
            lane_idx[i] = sum[AW-1:0];
            lane_on[i]  = !len_bad && (int'(len) > i) && !sum[AW];
        end
    end
endmodule

// File: rtl/hbcfg_store.sv
// Byte store: 256 bytes of flops with reset defaults, per-lane write
// ports and per-lane read ports. Assumes the enabled lanes of one access
// point at distinct bytes. Drops writes to fixed and masked bytes.
module hbcfg_store
    import hbcfg_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int NL = LANES,
    parameter int NB = CFG_BYTES,
    parameter int SB = SHADOW_BASE,
    parameter int SN = SHADOW_N
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NL-1:0]         wr_en,
    input  logic [NL-1:0][AW-1:0] lane_idx,
    input  logic [NL*8-1:0]       wdata,
    output logic [NL-1:0][7:0]    rd_byte,
    output logic [SN*8-1:0]       shadow
);
    logic [7:0] mem [NB];

    // Load defaults on reset, else store each enabled writable lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) mem[b] <= reset_value(AW'(b));
        end else begin
            for (int i = 0; i < NL; i++) begin
                if (wr_en[i] && byte_writable(lane_idx[i]))
                    mem[lane_idx[i]] <= wdata[i*8 +: 8];
            end
        end
    end

    for (genvar i = 0; i < NL; i++) begin : g_rd
        // Read port for lane i.
        always_comb rd_byte[i] = mem[lane_idx[i]];
    end

    for (genvar k = 0; k < SN; k++) begin : g_sh
        // Shadow attribute byte k taken straight from storage.
        always_comb shadow[k*8 +: 8] = mem[SB + k];
    end

    p_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == 8'h86 && mem[1] == 8'h80 && mem[2] == 8'h37 &&
        mem[3] == 8'h12 && mem[11] == 8'h06);
    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem[6] == 8'h80 && mem[12] == 8'h00);
endmodule

// File: rtl/hb_cfg_space.sv
// Top: host bridge configuration space target. One access per cycle from
// the configuration decoder; reads return one cycle later, little-endian.
// Assumes the decoder has already selected this target.
module hb_cfg_space
    import hbcfg_pkg::*;
#(
    parameter int AW = CFG_AW,
    parameter int NL = LANES,
    parameter int LW = LEN_W,
    parameter int SN = SHADOW_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_offset,
    input  logic [LW-1:0]   req_len,
    input  logic [NL*8-1:0] req_wdata,
    output logic            rsp_valid,
    output logic [NL*8-1:0] rsp_rdata,
    output logic [SN*8-1:0] shadow_attr
);
    logic [NL-1:0][AW-1:0] lane_idx;
    logic [NL-1:0]         lane_on;
    logic                  len_bad;
    logic [NL-1:0]         wr_en;
    logic [NL-1:0][7:0]    rd_byte;
    logic [NL*8-1:0]       rd_word;

    hbcfg_lane_map #(.AW(AW), .NL(NL), .LW(LW)) u_map (
        .offset(req_offset), .len(req_len),
        .lane_idx(lane_idx), .lane_on(lane_on), .len_bad(len_bad)
    );

    // Write enables only for live lanes of a write request.
    always_comb wr_en = (req_valid && req_write) ? lane_on : '0;

    hbcfg_store #(.AW(AW), .NL(NL), .SN(SN)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lane_idx(lane_idx),
        .wdata(req_wdata), .rd_byte(rd_byte), .shadow(shadow_attr)
    );

    // Assemble the read word: live lanes, zeros elsewhere, ones if too long.
    always_comb begin
        for (int i = 0; i < NL; i++)
            rd_word[i*8 +: 8] = lane_on[i] ? rd_byte[i] : 8'h00;
        if (len_bad) rd_word = '1;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rsp_rdata <= rd_word;
        end
    end

    p_rsp_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
    p_oversize_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(int'(req_len) > NL) |-> rsp_rdata == '1);
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_len == LW'(1)) |-> rsp_rdata[NL*8-1:8] == '0);
    p_clip_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_offset == '1 && req_len != '0 && int'(req_len) <= NL)
        |-> rsp_rdata[NL*8-1:8] == '0);
endmodule

// File: tb/tb_hb_cfg_space.sv
module tb_hb_cfg_space;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offset = '0;
    logic [2:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [55:0] shadow_attr;

    int errors = 0;
    int checks = 0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    hb_cfg_space dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .shadow_attr(shadow_attr)
    );

    function automatic logic [7:0] exp_reset(int b);
        case (b)
            'h00: return 8'h86; 'h01: return 8'h80; 'h02: return 8'h37;
            'h03: return 8'h12; 'h0B: return 8'h06; 'h04: return 8'h06;
            'h06: return 8'h80; 'h07: return 8'h02; 'h51: return 8'h01;
            'h53: return 8'h80; 'h57: return 8'h01; 'h58: return 8'h10;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit keeps_write(int b);
        return !(b inside {0, 1, 2, 3, 'h06, 'h0B, 'h0C});
    endfunction

    function automatic logic [31:0] exp_read(int off, int len);
        logic [31:0] v = '0;
        if (len > 4) return 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++)
            if (off + i <= 255) v[i*8 +: 8] = model[off + i];
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(int off, int len, logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_offset = 8'(off); req_len = 3'(len); req_wdata = data;
        if (len >= 1 && len <= 4)
            for (int i = 0; i < len; i++)
                if (off + i <= 255 && keeps_write(off + i))
                    model[off + i] = data[i*8 +: 8];
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(int off, int len, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_offset = 8'(off); req_len = 3'(len);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R10 valid"}, 64'(rsp_valid), 64'd1);
        check(tag, 64'(rsp_rdata), 64'(exp_read(off, len)));
    endtask

    task automatic check_shadow(string tag);
        logic [55:0] e;
        for (int k = 0; k < 7; k++) e[k*8 +: 8] = model['h59 + k];
        check(tag, 64'(shadow_attr), 64'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 256; b++) model[b] = exp_reset(b);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", 64'(rsp_valid), 64'd0);

        // R2 R3 R1: every byte after reset
        for (int b = 0; b < 256; b++) do_read(b, 1, "R2 R3 R1 reset byte");
        check_shadow("R9 R3 shadow reset");

        // R5: oversize and zero-length accesses
        for (int l = 5; l < 8; l++) do_read(8'h40, l, "R5 oversize read");
        do_read(8'h10, 0, "R5 zero-length read");
        do_write(8'h20, 0, 32'hDEAD_BEEF);
        do_write(8'h20, 6, 32'hDEAD_BEEF);
        do_read(8'h20, 4, "R5 ignored write");

        // R10: write produces no response
        do_write(8'h30, 1, 32'h0000_0011);
        check("R10 no rsp after write", 64'(rsp_valid), 64'd0);

        // R6 R7 R8 R1: every offset with every length, then full readback
        for (int l = 1; l <= 4; l++) begin
            for (int o = 0; o < 256; o++)
                do_write(o, l, (32'(o) * 32'h0101_0101) ^ (32'hA53C_96E1 + 32'(l * 77)));
            for (int o = 0; o < 256; o++) do_read(o, 4, "R4 R6 R7 R8 R1 sweep");
            check_shadow("R9 shadow after sweep");
        end

        // R4: shorter read lengths over a band of offsets
        for (int l = 1; l <= 3; l++)
            for (int o = 'hF0; o < 256; o++) do_read(o, l, "R4 R8 short read");

        // R7: straddling write keeps neighbours of the masked bytes
        do_write(8'h05, 3, 32'h00C3_B2A1);
        do_read(8'h04, 4, "R7 straddle 0x06");
        do_write(8'h0B, 4, 32'h4433_2211);
        do_read(8'h0C, 4, "R7 R1 straddle 0x0B-0x0C");

        // R9: shadow follows a single write
        do_write(8'h5C, 2, 32'h0000_7E81);
        check_shadow("R9 shadow single write");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule